// File: doc/BRIEF.md
# Sandcastle Gate Pulse Generator

This block turns a multi-level timing pulse, already quantised into a two-bit level code and sampled on the pixel-rate clock, into the separate timing gates that a colour decoder uses. The lowest threshold marks combined horizontal and vertical blanking. The highest marks the burst key. Horizontal blanking is the combined blanking with the vertical interval removed. A blanking run counts as vertical when it lasts longer than a programmable number of nominal horizontal-blank widths.

The burst key drives two further gates. One is a copy delayed by a fixed number of clock cycles (about 2 µs at the pixel rate), used to time the frequency-identification window. The other is an amplitude-measurement enable for the automatic colour control. It follows the burst key but is held off while the vertical-blanking flag is set, so that lines without burst cannot upset the gain loop. A one-cycle line tick marks the start of each horizontal blanking pulse.

Top module: `sc_gate_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every output is low, and the delayed gate holds no earlier burst.
- R2: `hvblank` is high in the cycle after a sample whose level code is 1, 2 or 3, and low in the cycle after a code of 0.
- R3: `burst_key` is high in the cycle after a sample whose code is 2 or 3 (code 3 behaves exactly as code 2), and low otherwise.
- R4: Let VB_LIMIT be HB_CYC × VB_MULT. `vblank` is high in the output cycle of the VB_LIMIT-th and every later consecutive nonzero sample, and falls with the first zero sample.
- R5: `hblank` equals `hvblank` while `vblank` is low, and is low while `vblank` is high.
- R6: `line_tick` is a single-cycle pulse in each cycle in which `hblank` is high after being low in the previous cycle.
- R7: `secam_gate` equals `burst_key` delayed by exactly DELAY_CYC cycles, so it keeps the same width and is unaffected by `vblank`.
- R8: `acc_enable` equals `burst_key` while `vblank` is low, and is low throughout `vblank`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| sc_level | input | 2 | Quantised level code: 0 none, 1 blanking, 2 blanking plus burst, 3 treated as 2 |
| burst_key | output | 1 | Burst key gate |
| hblank | output | 1 | Horizontal blanking gate |
| hvblank | output | 1 | Combined horizontal and vertical blanking gate |
| vblank | output | 1 | Vertical-blanking flag |
| line_tick | output | 1 | One-cycle pulse at the start of horizontal blanking |
| secam_gate | output | 1 | Delayed burst gate for frequency identification |
| acc_enable | output | 1 | Colour-control amplitude measurement enable |

## Verification
On every cycle, the assertions check how the gates nest: the burst key lies inside combined blanking, horizontal blanking and vblank never overlap, the tick lasts one cycle, the measurement enable is held off during vblank, and combined blanking follows the previous level code. Only the bench scenarios can show the exact run length at which vblank rises, that the delayed gate lags by exactly the set number of cycles, and that code 3 behaves like code 2. They do this by sweeping every four-sample code sequence and blanking runs just below, at and just above the vertical limit.

// File: rtl/sc_gate_pkg.sv
package sc_gate_pkg;

    typedef enum logic [1:0] {
        LVL_NONE  = 2'd0,
        LVL_BLANK = 2'd1,
        LVL_BURST = 2'd2,
        LVL_RSVD  = 2'd3
    } sc_level_e;

    typedef struct packed {
        logic burst;
        logic blank;
    } gate_pair_t;

    // Map a level code onto the two raw gates; the reserved code acts as burst.
    function automatic gate_pair_t decode_level(input logic [1:0] code);
        gate_pair_t g;
        g.blank = (code != LVL_NONE);
        g.burst = (code == LVL_BURST) || (code == LVL_RSVD);
        return g;
    endfunction

    // Saturating increment used by the run-length counter.
    function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
        return (v >= lim) ? lim : v + 1;
    endfunction

endpackage

// File: rtl/sc_level_decode.sv
module sc_level_decode
    import sc_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] level,
    output gate_pair_t raw_now,
    output gate_pair_t gates_q
);
    assign raw_now = decode_level(level);

    always_ff @(posedge clk) begin
        if (rst) begin
            gates_q <= '0;
        end else begin
            gates_q <= raw_now;
        end
    end
endmodule

// File: rtl/sc_vblank_detect.sv
module sc_vblank_detect
    import sc_gate_pkg::*;
#(
    parameter int unsigned HB_CYC  = 12,
    parameter int unsigned VB_MULT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic blank_now,
    output logic vblank_q
);
    localparam int unsigned VB_LIMIT = HB_CYC * VB_MULT;
    localparam int unsigned CW       = $clog2(VB_LIMIT + 1);

    logic [CW-1:0] run_q;
    logic [CW-1:0] run_d;

    always_comb begin
        if (blank_now) begin
            run_d = CW'(sat_inc(int'(run_q), VB_LIMIT));
        end else begin
            run_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= '0;
            vblank_q <= 1'b0;
        end else begin
            run_q    <= run_d;
            vblank_q <= blank_now && (int'(run_d) >= VB_LIMIT);
        end
    end
endmodule

// File: rtl/sc_delay_line.sv
module sc_delay_line #(
    parameter int unsigned DEPTH = 54
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    generate
        if (DEPTH == 1) begin : g_single
            logic stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= 1'b0;
                else     stage_q <= din;
            end
            assign dout = stage_q;
        end else begin : g_chain
            logic [DEPTH-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[DEPTH-2:0], din};
            end
            assign dout = chain_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/sc_gate_gen.sv
module sc_gate_gen
    import sc_gate_pkg::*;
#(
    parameter int unsigned DELAY_CYC = 54,
    parameter int unsigned HB_CYC    = 12,
    parameter int unsigned VB_MULT   = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sc_level,
    output logic       burst_key,
    output logic       hblank,
    output logic       hvblank,
    output logic       vblank,
    output logic       line_tick,
    output logic       secam_gate,
    output logic       acc_enable
);
    gate_pair_t raw_now;
    gate_pair_t gates_q;
    logic       vb_q;
    logic       hb_prev_q;
    logic       hb_now;

    sc_level_decode u_decode (
        .clk     (clk),
        .rst     (rst),
        .level   (sc_level),
        .raw_now (raw_now),
        .gates_q (gates_q)
    );

    sc_vblank_detect #(
        .HB_CYC  (HB_CYC),
        .VB_MULT (VB_MULT)
    ) u_vdet (
        .clk       (clk),
        .rst       (rst),
        .blank_now (raw_now.blank),
        .vblank_q  (vb_q)
    );

    sc_delay_line #(
        .DEPTH (DELAY_CYC)
    ) u_delay (
        .clk  (clk),
        .rst  (rst),
        .din  (gates_q.burst),
        .dout (secam_gate)
    );

    assign hb_now = gates_q.blank && !vb_q;

    always_ff @(posedge clk) begin
        if (rst) hb_prev_q <= 1'b0;
        else     hb_prev_q <= hb_now;
    end

    assign burst_key  = gates_q.burst;
    assign hvblank    = gates_q.blank;
    assign vblank     = vb_q;
    assign hblank     = hb_now;
    assign line_tick  = hb_now && !hb_prev_q;
    assign acc_enable = gates_q.burst && !vb_q;
endmodule

// File: rtl/sc_gate_checker.sv
module sc_gate_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] sc_level,
    input logic       burst_key,
    input logic       hblank,
    input logic       hvblank,
    input logic       vblank,
    input logic       line_tick,
    input logic       secam_gate,
    input logic       acc_enable
);
    p_blank_follow_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (hvblank == ($past(sc_level) != 2'd0)));

    p_burst_in_blank_r3: assert property (@(posedge clk) disable iff (rst)
        burst_key |-> hvblank);

    p_vb_in_blank_r4: assert property (@(posedge clk) disable iff (rst)
        vblank |-> hvblank);

    p_vb_rise_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(vblank)) |-> $past(hvblank));

    p_hb_excl_r5: assert property (@(posedge clk) disable iff (rst)
        hblank |-> (hvblank && !vblank));

    p_tick_single_r6: assert property (@(posedge clk) disable iff (rst)
        line_tick |=> !line_tick);

    p_tick_on_hb_r6: assert property (@(posedge clk) disable iff (rst)
        line_tick |-> hblank);

    p_acc_gate_r8: assert property (@(posedge clk) disable iff (rst)
        acc_enable |-> (burst_key && !vblank));
endmodule

bind sc_gate_gen sc_gate_checker u_sc_gate_checker (
    .clk        (clk),
    .rst        (rst),
    .sc_level   (sc_level),
    .burst_key  (burst_key),
    .hblank     (hblank),
    .hvblank    (hvblank),
    .vblank     (vblank),
    .line_tick  (line_tick),
    .secam_gate (secam_gate),
    .acc_enable (acc_enable)
);

// File: tb/test_sc_gate_gen.sv
module test_sc_gate_gen;
    localparam int D   = 5;
    localparam int HB  = 4;
    localparam int VM  = 2;
    localparam int VBL = HB * VM;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sc_level = 2'd0;
    logic burst_key, hblank, hvblank, vblank, line_tick, secam_gate, acc_enable;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // reference state
    int run = 0;
    int ns  = 0;
    bit prev_hb = 0;
    bit bk_hist [0:63];

    always #2 clk = ~clk;

    sc_gate_gen #(.DELAY_CYC(D), .HB_CYC(HB), .VB_MULT(VM)) i_sc_gate_gen (
        .clk(clk), .rst(rst), .sc_level(sc_level),
        .burst_key(burst_key), .hblank(hblank), .hvblank(hvblank),
        .vblank(vblank), .line_tick(line_tick), .secam_gate(secam_gate),
        .acc_enable(acc_enable)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s at sample %0d: actual=%b expected=%b", req, what, ns, act, exp);
        end
    endtask

    task automatic model_clear();
        run = 0; ns = 0; prev_hb = 0;
        for (int i = 0; i < 64; i++) bk_hist[i] = 0;
    endtask

    task automatic check_quiet(input string req);
        chk(req, "burst_key", burst_key, 1'b0);
        chk(req, "hblank", hblank, 1'b0);
        chk(req, "hvblank", hvblank, 1'b0);
        chk(req, "vblank", vblank, 1'b0);
        chk(req, "line_tick", line_tick, 1'b0);
        chk(req, "secam_gate", secam_gate, 1'b0);
        chk(req, "acc_enable", acc_enable, 1'b0);
    endtask

    // R1: reset held with a nonzero level; outputs must stay low
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sc_level = 2'd2;
        repeat (3) begin
            @(negedge clk);
            check_quiet("R1");
        end
        sc_level = 2'd0;
        rst = 1'b0;
        model_clear();
    endtask

    task automatic step(input logic [1:0] lv);
        bit hv, bk, vb, hb, tk, sec;
        sc_level = lv;
        @(negedge clk);
        hv = (lv != 2'd0);
        bk = (lv >= 2'd2);
        run = hv ? ((run >= VBL) ? VBL : run + 1) : 0;
        vb = hv && (run >= VBL);
        hb = hv && !vb;
        tk = hb && !prev_hb;
        prev_hb = hb;
        sec = (ns >= D) ? bk_hist[(ns - D) % 64] : 1'b0;
        bk_hist[ns % 64] = bk;
        chk("R2", "hvblank", hvblank, hv);
        chk("R3", "burst_key", burst_key, bk);
        chk("R4", "vblank", vblank, vb);
        chk("R5", "hblank", hblank, hb);
        chk("R6", "line_tick", line_tick, tk);
        chk("R7", "secam_gate", secam_gate, sec);
        chk("R8", "acc_enable", acc_enable, bk && !vb);
        ns++;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();
        // R1: first cycle after release shows nothing from the reset period
        step(2'd0);

        // ordinary lines with varying burst widths (R3, R6, R7)
        for (int w = 1; w <= 7; w++) begin
            step(2'd1);
            for (int k = 0; k < w; k++) step((k % 2 == 0) ? 2'd2 : 2'd3);
            step(2'd1);
            for (int k = 0; k < 7; k++) step(2'd0);
        end

        // blanking runs around the vertical limit (R4, R5)
        for (int len = VBL - 2; len <= VBL + 3; len++) begin
            for (int k = 0; k < len; k++) step(2'd1);
            for (int k = 0; k < 3; k++) step(2'd0);
        end

        // vertical interval with bursts inside (R8 suppressed, R7 still delayed)
        for (int k = 0; k < 24; k++) step(((k % 5) == 2 || (k % 5) == 3) ? 2'd2 : 2'd1);
        for (int k = 0; k < 8; k++) step(2'd0);

        // exhaustive four-sample code sequences
        for (int c = 0; c < 256; c++) begin
            for (int j = 0; j < 4; j++) step(2'((c >> (2 * j)) & 3));
            step(2'd0);
        end

        // reset in the middle of a long run, then continue
        for (int k = 0; k < VBL + 2; k++) step(2'd2);
        do_reset();
        step(2'd1);
        for (int k = 0; k < VBL + 1; k++) step(2'd3);
        for (int k = 0; k < D + 3; k++) step(2'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule